// File: doc/BRIEF.md
# Transceiver automatic power-down controller

This block is the digital control that decides when the line drivers and the on-chip supply of a serial line transceiver run. Two control pins set the mode. An active-low force-off pin shuts the drivers and the supply down and wins over everything else. An active-high force-on pin keeps the drivers running. When neither pin is asserted, an automatic rule decides. The block also reports, on an active-low invalid pin, whether any receiver sees a valid line level. It produces the enables for the main receiver outputs and for the always-on receiver outputs.

A parameter selects the automatic rule. In the edge-timer variant, the drivers turn off after a programmable number of clock cycles (30 s at the default clock) with no edge on any transmit or receive data input. The next edge turns them back on. In the level-absence variant, the drivers are on exactly while at least one receiver reports a valid level, and a separate active-low receiver enable gates the main receiver outputs. Every pin and data input passes through a two-flop synchronizer whose flops clear to zero. As a result the block comes out of reset powered down, with the timer loaded to full, until the pins arrive through the synchronizer.

Top module: `trx_pd_ctrl`

## Requirements
- R1: While the synchronized force-off pin is low, tx_oe_o and pump_en_o are 0, whatever force-on, the activity and the valid flags are doing.
- R2: While force-off is high and force-on is high, tx_oe_o is 1 in both variants, whatever the line activity.
- R3: Edge-timer variant, force-off high and force-on low: tx_oe_o falls TIMEOUT_CYC clock edges after the last timer reload if no edge appears on any tx_data_i or rx_data_i bit. It stays low until an edge appears. The timer is loaded full by reset.
- R4: Edge-timer variant: an input data edge reloads the timer. A data change driven before clock edge k shows as tx_oe_o = 1 after edge k+2 (detected after k+1, driver enabled on the next clock).
- R5: invalid_no equals the OR of the rx_valid_i bits, delayed by two clock edges, in every mode and variant.
- R6: rx_aux_oe_o is 1 in every mode, including manual power-down.
- R7: Edge-timer variant: rx_oe_o is 0 only in manual power-down (force-off low). It stays 1 during force-on and during automatic power-down.
- R8: Level-absence variant, force-off high and force-on low: tx_oe_o is 1 exactly while at least one synchronized valid flag is 1.
- R9: Level-absence variant: rx_oe_o is the inverse of the synchronized rx_en_ni. This holds in manual power-down too.
- R10: pump_en_o equals tx_oe_o in every mode.
- R11: With both force pins tied to invalid_no, the drivers run while a valid level is present and are forced off while none is.
- R12: Changes on the force pins, on rx_en_ni or on rx_valid_i never reload the activity timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| force_off_ni | input | 1 | Manual shutdown, active low, highest priority |
| force_on_i | input | 1 | Keep drivers running, active high |
| rx_en_ni | input | 1 | Main receiver output enable, active low (level-absence variant) |
| tx_data_i | input | N_TX | Transmitter data inputs, watched for edges |
| rx_data_i | input | N_RX | Receiver data, watched for edges |
| rx_valid_i | input | N_RX | Per-receiver valid line level present |
| tx_oe_o | output | 1 | Transmitter output enable |
| pump_en_o | output | 1 | On-chip supply run enable |
| rx_oe_o | output | 1 | Main receiver output enable |
| rx_aux_oe_o | output | 1 | Always-on receiver output enable |
| invalid_no | output | 1 | Low when no receiver shows a valid level |

## Verification
Every pin reaches the outputs two clock edges after it changes. A data edge re-enables the drivers after three edges, and the drivers drop exactly TIMEOUT_CYC edges after the last reload. The bench keeps a history queue of the inputs it drove at each rising edge and a countdown of the idle edges. It compares all outputs of both variants against that model at every falling edge, so each result is checked in the cycle it is due. Directed checks also pin the wake-up latency to the exact cycle, and they confirm that toggling control and valid pins does not delay a timeout.

// File: rtl/trx_pd_pkg.sv
package trx_pd_pkg;
  typedef enum logic {
    PD_EDGE_TIMER   = 1'b0,
    PD_LEVEL_ABSENT = 1'b1
  } pd_variant_e;
endpackage

// File: rtl/trx_sync_bank.sv
module trx_sync_bank #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/trx_act_timer.sv
module trx_act_timer #(
  parameter int unsigned DATA_W      = 2,
  parameter int unsigned TIMEOUT_CYC = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic              act_o,
  output logic              expired_o
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(TIMEOUT_CYC);

  logic [DATA_W-1:0] prev_q;
  logic [CNT_W-1:0]  cnt_q;

  assign act_o     = (data_i != prev_q);
  assign expired_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      cnt_q  <= LOAD;
    end else begin
      prev_q <= data_i;
      if (act_o)            cnt_q <= LOAD;
      else if (!expired_o)  cnt_q <= cnt_q - 1'b1;
    end
  end

  // R4
  wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o |=> !expired_o);

  // R3
  hold_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !act_o) |=> expired_o);
endmodule

// File: rtl/trx_pd_arbiter.sv
module trx_pd_arbiter
  import trx_pd_pkg::*;
#(
  parameter pd_variant_e VARIANT = PD_EDGE_TIMER
) (
  input  logic force_off_ni,
  input  logic force_on_i,
  input  logic rx_en_ni,
  input  logic any_valid_i,
  input  logic expired_i,
  output logic tx_oe_o,
  output logic rx_oe_o
);
  logic auto_on;
  logic unused_sink;

  if (VARIANT == PD_EDGE_TIMER) begin : g_edge
    assign auto_on     = !expired_i;
    assign rx_oe_o     = force_off_ni;
    assign unused_sink = ^{rx_en_ni, any_valid_i};
  end else begin : g_level
    assign auto_on     = any_valid_i;
    assign rx_oe_o     = !rx_en_ni;
    assign unused_sink = expired_i;
  end

  // manual off > force on > automatic rule
  assign tx_oe_o = force_off_ni && (force_on_i || auto_on);
endmodule

// File: rtl/trx_pd_ctrl.sv
module trx_pd_ctrl
  import trx_pd_pkg::*;
#(
  parameter int unsigned N_TX        = 2,
  parameter int unsigned N_RX        = 2,
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned TIMEOUT_S   = 30,
  parameter int unsigned TIMEOUT_CYC = CLK_HZ * TIMEOUT_S,
  parameter pd_variant_e VARIANT     = PD_EDGE_TIMER
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            force_off_ni,
  input  logic            force_on_i,
  input  logic            rx_en_ni,
  input  logic [N_TX-1:0] tx_data_i,
  input  logic [N_RX-1:0] rx_data_i,
  input  logic [N_RX-1:0] rx_valid_i,
  output logic            tx_oe_o,
  output logic            pump_en_o,
  output logic            rx_oe_o,
  output logic            rx_aux_oe_o,
  output logic            invalid_no
);
  localparam int unsigned DW = N_TX + N_RX;
  localparam int unsigned SW = DW + 3 + N_RX;

  logic [SW-1:0]   raw_v, sync_v;
  logic [DW-1:0]   data_s;
  logic [N_RX-1:0] valid_s;
  logic            force_off_s, force_on_s, rx_en_s;
  logic            any_valid, expired;

  assign raw_v = {rx_valid_i, rx_en_ni, force_on_i, force_off_ni, rx_data_i, tx_data_i};

  trx_sync_bank #(.W(SW)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_v),
    .q_o   (sync_v)
  );

  assign data_s      = sync_v[DW-1:0];
  assign force_off_s = sync_v[DW];
  assign force_on_s  = sync_v[DW+1];
  assign rx_en_s     = sync_v[DW+2];
  assign valid_s     = sync_v[SW-1 -: N_RX];
  assign any_valid   = |valid_s;

  if (VARIANT == PD_EDGE_TIMER) begin : g_timer
    logic act_unused;
    trx_act_timer #(.DATA_W(DW), .TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .data_i   (data_s),
      .act_o    (act_unused),
      .expired_o(expired)
    );
  end else begin : g_no_timer
    logic data_unused;
    assign data_unused = ^data_s;
    assign expired     = 1'b0;
  end

  trx_pd_arbiter #(.VARIANT(VARIANT)) u_arb (
    .force_off_ni(force_off_s),
    .force_on_i  (force_on_s),
    .rx_en_ni    (rx_en_s),
    .any_valid_i (any_valid),
    .expired_i   (expired),
    .tx_oe_o     (tx_oe_o),
    .rx_oe_o     (rx_oe_o)
  );

  assign pump_en_o   = tx_oe_o;
  assign rx_aux_oe_o = 1'b1;
  assign invalid_no  = any_valid;

  // R1
  manual_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !force_off_s |-> (!tx_oe_o && !pump_en_o));

  // R2
  force_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_off_s && force_on_s) |-> tx_oe_o);

  // R5
  invalid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(invalid_no) |-> $past(|rx_valid_i, 2));

  // R5
  invalid_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(invalid_no) |-> !$past(|rx_valid_i, 2));
endmodule

// File: tb/trx_pd_ctrl_test.sv
module trx_pd_ctrl_test;
  import trx_pd_pkg::*;

  localparam int NT = 3;
  localparam int NR = 2;
  localparam int T  = 20;
  localparam int DW = NT + NR;
  localparam int PW = DW + 3 + NR;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic          foff_drv = 1'b1, fon_drv = 1'b0, ren_n = 1'b0, tie = 1'b0;
  logic [NT-1:0] txd = '0;
  logic [NR-1:0] rxd = '0, vld = '0;

  logic e_tx, e_pump, e_rx, e_aux, e_inv;
  logic l_tx, l_pump, l_rx, l_aux, l_inv;
  logic foff_e, fon_e, foff_l, fon_l;

  assign foff_e = tie ? e_inv : foff_drv;
  assign fon_e  = tie ? e_inv : fon_drv;
  assign foff_l = tie ? l_inv : foff_drv;
  assign fon_l  = tie ? l_inv : fon_drv;

  trx_pd_ctrl #(.N_TX(NT), .N_RX(NR), .TIMEOUT_CYC(T), .VARIANT(PD_EDGE_TIMER)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .force_off_ni(foff_e), .force_on_i(fon_e),
    .rx_en_ni(ren_n), .tx_data_i(txd), .rx_data_i(rxd), .rx_valid_i(vld),
    .tx_oe_o(e_tx), .pump_en_o(e_pump), .rx_oe_o(e_rx), .rx_aux_oe_o(e_aux),
    .invalid_no(e_inv));

  trx_pd_ctrl #(.N_TX(NT), .N_RX(NR), .TIMEOUT_CYC(T), .VARIANT(PD_LEVEL_ABSENT)) uut_lvl (
    .clk_i(clk), .rst_ni(rst_ni), .force_off_ni(foff_l), .force_on_i(fon_l),
    .rx_en_ni(ren_n), .tx_data_i(txd), .rx_data_i(rxd), .rx_valid_i(vld),
    .tx_oe_o(l_tx), .pump_en_o(l_pump), .rx_oe_o(l_rx), .rx_aux_oe_o(l_aux),
    .invalid_no(l_inv));

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model: inputs seen at each rising edge, idle countdown
  logic [PW-1:0] hist[$] = '{'0, '0, '0};
  logic [PW-1:0] cur_v;
  int remain = T;

  always @(posedge clk) begin
    if (!rst_ni) begin
      hist   = '{'0, '0, '0};
      remain = T;
    end else begin
      cur_v = {vld, ren_n, fon_e, foff_e, rxd, txd};
      if (hist[1][DW-1:0] != hist[2][DW-1:0]) remain = T;
      else if (remain > 0) remain--;
      hist.push_front(cur_v);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    logic [PW-1:0] v;
    logic m_off, m_on, m_ren, m_any, x_e, x_l;
    string te, tl;
    v     = hist[1];
    m_off = v[DW];
    m_on  = v[DW+1];
    m_ren = v[DW+2];
    m_any = |v[PW-1 -: NR];
    x_e   = m_off && (m_on || remain > 0);
    x_l   = m_off && (m_on || m_any);
    te    = tie ? "R11" : !m_off ? "R1" : m_on ? "R2" : "R3";
    tl    = tie ? "R11" : !m_off ? "R1" : m_on ? "R2" : "R8";
    chk(e_tx, x_e, te, "edge tx_oe");
    chk(l_tx, x_l, tl, "level tx_oe");
    chk(e_pump, x_e, "R10", "edge pump_en");
    chk(l_pump, x_l, "R10", "level pump_en");
    chk(e_inv, m_any, "R5", "edge invalid_n");
    chk(l_inv, m_any, "R5", "level invalid_n");
    chk(e_rx, m_off, "R7", "edge rx_oe");
    chk(l_rx, !m_ren, "R9", "level rx_oe");
    chk(e_aux, 1'b1, "R6", "edge aux_oe");
    chk(l_aux, 1'b1, "R6", "level aux_oe");
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step(3);
    // reset state: powered down
    chk(e_tx, 1'b0, "R1", "reset tx_oe");
    chk(e_aux, 1'b1, "R6", "reset aux_oe");
    rst_ni = 1'b1;
    fon_drv = 1'b1;
    vld = 2'b01;
    step(5);
    txd = 3'b101;
    step(3);
    rxd = 2'b10;
    step(30);
    chk(e_tx, 1'b1, "R2", "force-on past timeout");
    // automatic mode, already idle
    fon_drv = 1'b0;
    step(10);
    chk(e_tx, 1'b0, "R3", "idle timed out");
    chk(e_rx, 1'b1, "R7", "rx on in auto off");
    // wake-up latency
    txd[0] = ~txd[0];
    step(1);
    chk(e_tx, 1'b0, "R4", "wake after 1 edge");
    step(1);
    chk(e_tx, 1'b0, "R4", "wake after 2 edges");
    step(1);
    chk(e_tx, 1'b1, "R4", "wake after 3 edges");
    step(T + 5);
    rxd[1] = ~rxd[1];
    step(5);
    chk(e_tx, 1'b1, "R4", "rx edge wake");
    // control and valid toggles must not reload the timer
    for (int i = 0; i < T + 6; i++) begin
      if (i % 3 == 0) begin
        ren_n  = ~ren_n;
        vld[1] = ~vld[1];
      end
      step(1);
    end
    chk(e_tx, 1'b0, "R12", "timeout despite control toggles");
    ren_n = 1'b0;
    vld = 2'b00;
    step(6);
    chk(l_tx, 1'b0, "R8", "level off without valid");
    vld = 2'b10;
    step(6);
    chk(l_tx, 1'b1, "R8", "level on with valid");
    // manual override beats force-on and activity
    foff_drv = 1'b0;
    fon_drv  = 1'b1;
    for (int i = 0; i < 12; i++) begin
      txd = txd + 3'd1;
      if (i % 4 == 0) ren_n = ~ren_n;
      step(1);
    end
    chk(e_tx, 1'b0, "R1", "manual off under activity");
    chk(e_aux, 1'b1, "R6", "aux on in manual");
    foff_drv = 1'b1;
    fon_drv  = 1'b0;
    ren_n    = 1'b0;
    step(4);
    // force pins tied to invalid
    tie = 1'b1;
    vld = 2'b00;
    step(8);
    chk(e_tx, 1'b0, "R11", "tied, no valid");
    vld = 2'b01;
    step(8);
    chk(e_tx, 1'b1, "R11", "tied, valid");
    chk(l_tx, 1'b1, "R11", "tied level, valid");
    vld = 2'b00;
    step(8);
    chk(l_tx, 1'b0, "R11", "tied level, no valid");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule